// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of one 32-bit conditional branch instruction with a 14-bit displacement for each request it accepts. The requester presents the instruction word, the address of that instruction, the 32-bit condition register and the count register. It does so through a valid/ready handshake. One cycle later the block offers a registered response. The response holds the next instruction address, whether the branch was taken, the new count value with its write enable, a link-register write enable with its data, the static prediction hint copied from the instruction, and an illegal flag.

The five option bits set up two tests. The first is a count test. It may first decrement the count register and then look at whether the result is zero, in either polarity. The second is a test on one selected condition-register bit, also in either polarity. An option bit can switch off each test so that it always passes. The branch is taken only when both tests pass. A link write happens whenever the link bit is set, whatever the outcome.

Top module: `branch_resolver`

## Requirements
- R1: Bit numbering in the instruction word counts from the LSB (bit 31 = MSB). A word whose bits [31:26] are not 16 is illegal. Its response has illegal=1, taken=0, ctr_we=0, lr_we=0, hint=0, ctr_out equal to the supplied count, and nia equal to cia+4.
- R2: With opt bit c clear (instr[23]=0), the response has ctr_we=1 and ctr_out = count−1, wrapping at zero. With instr[23]=1 it has ctr_we=0 and ctr_out = count.
- R3: The count test passes when instr[23]=1. Otherwise it passes when (decremented count ≠ 0) differs from instr[22]. The zero check looks only at the low 32 bits.
- R4: The condition test passes when instr[25]=1. Otherwise it passes when cr_in[31−S] equals instr[24], where S = instr[20:16] and condition bit 0 is the MSB of cr_in.
- R5: taken=1 exactly when the count test and the condition test both pass on a legal word.
- R6: On a taken branch, the offset is instr[15:2] read as a signed word count and multiplied by 4. nia = cia + offset when instr[1]=0, and nia = offset sign-extended when instr[1]=1.
- R7: On a branch that is not taken, nia = cia + 4.
- R8: When instr[0]=1 on a legal word, lr_we=1 and lr_data = cia+4, for both outcomes. When instr[0]=0, lr_we=0.
- R9: hint equals instr[21] on a legal word. Flipping instr[21] changes no other output.
- R10: A request is accepted when req_valid and req_ready are both high, and its response is visible on rsp_valid in the next cycle. req_ready = !rsp_valid || rsp_ready. While rsp_valid is high and rsp_ready is low, the response is held unchanged.
- R11: After reset, rsp_valid=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| instr | input | 32 | Branch instruction word |
| cia | input | ADDR_W | Address of the instruction |
| cr_in | input | 32 | Condition register |
| ctr_in | input | CTR_W | Count register |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| nia | output | ADDR_W | Next instruction address |
| taken | output | 1 | Branch taken |
| ctr_out | output | CTR_W | Count register value after the instruction |
| ctr_we | output | 1 | Count register must be written |
| lr_we | output | 1 | Link register must be written |
| lr_data | output | ADDR_W | Link register value |
| hint | output | 1 | Static prediction hint (1 = predict taken) |
| illegal | output | 1 | Opcode is not a conditional branch |

## Verification
Each response depends only on the request that produced it, so a wrong internal value shows up in the very next response. The ports reveal it within one cycle of acceptance.

- A decrement applied at the wrong point, or a zero test run on the old count, flips taken. This happens only when the count crosses one or zero, so counts of 0, 1 and 2 are driven on purpose.
- A wrong condition-bit index or polarity shows as a wrong taken flag only on some register patterns. Both set and clear bits are applied at the low and high indices.
- An offset that is not sign-extended shows as a wrong nia only for negative displacements.
- A broken hold path shows as a response that changes under a stalled consumer.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam logic [5:0] OPCD_BCOND = 6'd16;

  typedef struct packed {
    logic [5:0]  opcd;
    logic [4:0]  opt;    // opt[4] is the first option bit (word bit 25)
    logic [4:0]  sel;
    logic [13:0] disp;
    logic        absa;
    logic        link;
  } bfields_t;

  // option bit k, counting from the most significant option bit
  function automatic logic opt_bit(input logic [4:0] opt, input int k);
    return opt[4-k];
  endfunction

  // word displacement scaled to bytes, sign extended to 64 bits
  function automatic logic [63:0] disp_bytes(input logic [13:0] d);
    return {{48{d[13]}}, d, 2'b00};
  endfunction

  // condition bit s, bit 0 being the MSB of the register
  function automatic logic cr_pick(input logic [31:0] cr, input logic [4:0] s);
    return cr[5'd31 - s];
  endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [31:0] instr,
  output bfields_t    fld,
  output logic        legal
);
  always_comb begin
    fld.opcd = instr[31:26];
    fld.opt  = instr[25:21];
    fld.sel  = instr[20:16];
    fld.disp = instr[15:2];
    fld.absa = instr[1];
    fld.link = instr[0];
    legal    = (instr[31:26] == OPCD_BCOND);
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic [4:0]       opt,
  input  logic [4:0]       sel,
  input  logic [31:0]      cr_in,
  input  logic [CTR_W-1:0] ctr_in,
  output logic [CTR_W-1:0] ctr_next,
  output logic             dec_req,
  output logic             ctr_ok,
  output logic             cr_ok
);
  localparam int CHK_W = (CTR_W < 32) ? CTR_W : 32;

  logic ctr_zero;

  always_comb begin
    dec_req  = !opt_bit(opt, 2);
    ctr_next = dec_req ? ctr_in - CTR_W'(1) : ctr_in;
    ctr_zero = (ctr_next[CHK_W-1:0] == '0);
    ctr_ok   = opt_bit(opt, 2) | ((!ctr_zero) ^ opt_bit(opt, 3));
    cr_ok    = opt_bit(opt, 0) | (cr_pick(cr_in, sel) == opt_bit(opt, 1));
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cia,
  input  logic [13:0]       disp,
  input  logic              absa,
  input  logic              go,
  output logic [ADDR_W-1:0] nia,
  output logic [ADDR_W-1:0] seq_addr
);
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] tgt;

  always_comb begin
    offs     = disp_bytes(disp)[ADDR_W-1:0];
    seq_addr = cia + ADDR_W'(4);
    tgt      = absa ? offs : cia + offs;
    nia      = go ? tgt : seq_addr;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import bru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] cia,
  input  logic [31:0]       cr_in,
  input  logic [CTR_W-1:0]  ctr_in,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] nia,
  output logic              taken,
  output logic [CTR_W-1:0]  ctr_out,
  output logic              ctr_we,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_data,
  output logic              hint,
  output logic              illegal
);
  bfields_t          fld;
  logic              legal;
  logic [CTR_W-1:0]  ctr_next;
  logic              dec_req, ctr_ok, cr_ok, go;
  logic [ADDR_W-1:0] nia_c, seq_addr;
  logic              accept;

  bru_decode u_dec (.instr(instr), .fld(fld), .legal(legal));

  bru_cond #(.CTR_W(CTR_W)) u_cond (
    .opt(fld.opt), .sel(fld.sel), .cr_in(cr_in), .ctr_in(ctr_in),
    .ctr_next(ctr_next), .dec_req(dec_req), .ctr_ok(ctr_ok), .cr_ok(cr_ok)
  );

  assign go = legal & ctr_ok & cr_ok;

  bru_target #(.ADDR_W(ADDR_W)) u_tgt (
    .cia(cia), .disp(fld.disp), .absa(fld.absa), .go(go),
    .nia(nia_c), .seq_addr(seq_addr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      nia       <= '0;
      taken     <= 1'b0;
      ctr_out   <= '0;
      ctr_we    <= 1'b0;
      lr_we     <= 1'b0;
      lr_data   <= '0;
      hint      <= 1'b0;
      illegal   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      nia       <= nia_c;
      taken     <= go;
      ctr_out   <= legal ? ctr_next : ctr_in;
      ctr_we    <= legal & dec_req;
      lr_we     <= legal & fld.link;
      lr_data   <= seq_addr;
      hint      <= legal & opt_bit(fld.opt, 4);
      illegal   <= !legal;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_accept_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(nia) && $stable(ctr_out) && $stable(taken)));

  p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && illegal) |-> (!ctr_we && !lr_we && !taken));

  p_ctr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal && dec_req) |=> (ctr_we && ctr_out == $past(ctr_in) - CTR_W'(1)));

  p_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal && fld.link) |=> (lr_we && lr_data == $past(cia) + ADDR_W'(4)));

  p_taken_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && taken) |-> !illegal);

endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] instr = '0, cia = '0, cr_in = '0, ctr_in = '0;
  logic        req_ready, rsp_valid, taken, ctr_we, lr_we, hint, illegal;
  logic [31:0] nia, ctr_out, lr_data;

  int checks = 0, errors = 0;

  typedef struct {
    logic [31:0] nia;
    logic        taken;
    logic [31:0] ctr;
    logic        ctr_we;
    logic        lr_we;
    logic [31:0] lr;
    logic        hint;
    logic        illegal;
  } exp_t;

  exp_t  mdl;
  logic  mv = 1'b0;
  string mtag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver u_branch_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .instr(instr), .cia(cia), .cr_in(cr_in), .ctr_in(ctr_in),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .nia(nia), .taken(taken),
    .ctr_out(ctr_out), .ctr_we(ctr_we), .lr_we(lr_we), .lr_data(lr_data),
    .hint(hint), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input int op, input int opts, input int s,
                                     input int bd, input int aa, input int lk);
    return (32'(op) << 26) | ((32'(opts) & 32'h1f) << 21) | ((32'(s) & 32'h1f) << 16)
         | ((32'(bd) & 32'h3fff) << 2) | (32'(aa) << 1) | 32'(lk);
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] cr, input logic [31:0] c);
    exp_t e;
    int   bdv, sidx;
    logic [31:0] newc, off, tgt;
    logic c_ok, r_ok;
    e.lr = a + 32'd4;
    if (w[31:26] != 6'd16) begin
      e.illegal = 1'b1; e.taken = 1'b0; e.nia = a + 32'd4; e.ctr = c;
      e.ctr_we = 1'b0; e.lr_we = 1'b0; e.hint = 1'b0;
      return e;
    end
    e.illegal = 1'b0;
    newc = w[23] ? c : c - 32'd1;
    e.ctr = newc; e.ctr_we = !w[23];
    c_ok = w[23] || ((newc != 0) != w[22]);
    sidx = int'(w[20:16]);
    r_ok = w[25] || (cr[31 - sidx] == w[24]);
    e.taken = c_ok && r_ok;
    bdv = int'(w[15:2]);
    if (bdv >= 8192) bdv = bdv - 16384;
    off = 32'(bdv * 4);
    tgt = w[1] ? off : a + off;
    e.nia = e.taken ? tgt : a + 32'd4;
    e.lr_we = w[0];
    e.hint = w[21];
    return e;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(32'(rsp_valid), 32'(mv), "R10 rsp_valid");
    if (mv) begin
      chk(32'(illegal), 32'(mdl.illegal), "R1 illegal");
      chk(32'(taken), 32'(mdl.taken), {"R5 taken ", mtag});
      chk(nia, mdl.nia, mdl.taken ? "R6 nia" : "R7 nia");
      chk(ctr_out, mdl.ctr, "R2 ctr_out");
      chk(32'(ctr_we), 32'(mdl.ctr_we), "R2 ctr_we");
      chk(32'(lr_we), 32'(mdl.lr_we), "R8 lr_we");
      if (mdl.lr_we) chk(lr_data, mdl.lr, "R8 lr_data");
      chk(32'(hint), 32'(mdl.hint), "R9 hint");
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] cr, input logic [31:0] c, input logic rr,
                      input string tag);
    logic acc;
    check_outputs();
    req_valid = v; instr = w; cia = a; cr_in = cr; ctr_in = c; rsp_ready = rr;
    #1;
    chk(32'(req_ready), 32'(!mv || rr), "R10 req_ready");
    acc = v && (!mv || rr);
    if (acc) begin
      mdl = model(w, a, cr, c); mv = 1'b1; mtag = tag;
    end else if (rr) begin
      mv = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(rsp_valid), 32'd0, "R11 rsp_valid after reset");
    chk(32'(req_ready), 32'd1, "R11 req_ready after reset");

    // R3: count-only branch on nonzero, counts 2, 1 and 0 (wrap, R2)
    step(1, mk(16, 5'b10000, 0, 5, 0, 0), 32'h1000, 0, 2, 1, "R3 dnz 2");
    step(1, mk(16, 5'b10000, 0, 5, 0, 0), 32'h1000, 0, 1, 1, "R3 dnz 1");
    step(1, mk(16, 5'b10000, 0, 5, 0, 0), 32'h1000, 0, 0, 1, "R2 wrap");
    // R3: count-only branch on zero
    step(1, mk(16, 5'b10010, 0, -3, 0, 0), 32'h2000, 0, 1, 1, "R3 dz 1");
    step(1, mk(16, 5'b10010, 0, -3, 0, 0), 32'h2000, 0, 7, 1, "R3 dz 7");
    // R4: condition polarity, low and high bit indices
    step(1, mk(16, 5'b01100, 2, 8, 0, 0), 32'h3000, 32'h2000_0000, 9, 1, "R4 true set");
    step(1, mk(16, 5'b01100, 2, 8, 0, 0), 32'h3000, 32'hDFFF_FFFF, 9, 1, "R4 true clr");
    step(1, mk(16, 5'b00100, 31, 8, 0, 0), 32'h3000, 32'h0000_0001, 9, 1, "R4 false set");
    step(1, mk(16, 5'b00100, 31, 8, 0, 0), 32'h3000, 32'hFFFF_FFFE, 9, 1, "R4 false clr");
    // R5: both tests combined; one fails
    step(1, mk(16, 5'b01000, 0, 4, 0, 0), 32'h4000, 32'h8000_0000, 5, 1, "R5 both");
    step(1, mk(16, 5'b01000, 0, 4, 0, 0), 32'h4000, 32'h8000_0000, 1, 1, "R5 ctr fails");
    // R6: branch always, negative relative and absolute targets
    step(1, mk(16, 5'b10100, 0, -8192, 0, 0), 32'h0001_0000, 0, 3, 1, "R6 rel min");
    step(1, mk(16, 5'b10100, 0, 8191, 0, 0), 32'h0001_0000, 0, 3, 1, "R6 rel max");
    step(1, mk(16, 5'b10100, 0, -2, 1, 0), 32'h0001_0000, 0, 3, 1, "R6 abs neg");
    // R8: link on taken and not taken
    step(1, mk(16, 5'b10100, 0, 1, 0, 1), 32'h5000, 0, 3, 1, "R8 taken");
    step(1, mk(16, 5'b01100, 0, 1, 0, 1), 32'h5000, 0, 3, 1, "R8 not taken");
    // R9: hint bit flipped, outcome unchanged
    step(1, mk(16, 5'b01100, 3, 6, 0, 0), 32'h6000, 32'h1000_0000, 3, 1, "R9 hint0");
    step(1, mk(16, 5'b01101, 3, 6, 0, 0), 32'h6000, 32'h1000_0000, 3, 1, "R9 hint1");
    // R1: wrong opcodes
    step(1, mk(18, 5'b10000, 0, 5, 0, 1), 32'h7000, 0, 4, 1, "R1 op18");
    step(1, mk(0, 5'b00000, 0, 5, 0, 1), 32'h7000, 0, 0, 1, "R1 op0");
    // R10: stall the consumer, then release
    step(1, mk(16, 5'b10000, 0, 2, 0, 1), 32'h8000, 0, 9, 0, "R10 first");
    step(1, mk(16, 5'b10100, 0, 3, 0, 0), 32'h9000, 0, 9, 0, "R10 blocked");
    step(1, mk(16, 5'b10100, 0, 3, 0, 0), 32'h9000, 0, 9, 0, "R10 blocked");
    step(0, 0, 0, 0, 0, 1, "R10 drain");
    step(0, 0, 0, 0, 0, 1, "idle");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w, c;
      w = $urandom;
      if (($urandom % 8) != 0) w[31:26] = 6'd16;
      c = (($urandom % 2) == 0) ? 32'($urandom % 3) : $urandom;
      step(($urandom % 4) != 0, w, $urandom & 32'hFFFF_FFFC, $urandom, c,
           ($urandom % 3) != 0, "rand");
    end
    step(0, 0, 0, 0, 0, 1, "end");
    step(0, 0, 0, 0, 0, 1, "end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule